// File: doc/BRIEF.md
# Read Address Sequence Command Detector

This block watches a memory access stream and turns one strict pattern of six reads into a command. Each access shows up for exactly one clock cycle on a read strobe or a write strobe, with a 15-bit address. Five fixed prefix addresses must be read in order. A sixth read then selects the command: one address asks for a store (volatile contents copied into the nonvolatile array) and another asks for a recall (nonvolatile contents copied back into the volatile array). A write, or a read at any other address, breaks the pattern and no command is issued.

When a command is accepted, the block raises a one-cycle start pulse and keeps `busy` high for a set number of cycles. While `busy` is high the surrounding memory must refuse all traffic, and the detector ignores every access. A store runs as an erase phase and then a program phase. A recall is a single timed phase. The nonvolatile array is not modelled; cycle counters stand in for it.

Top module: `rdseq_cmd_top`

## Requirements
- R1: While reset is held and after it is released, `busy`, both start pulses and all three phase flags are 0.
- R2: After five reads at 0x0E38, 0x31C7, 0x03E0, 0x3C1F and 0x303F, in that order, a read at 0x0FC0 makes `store_start` high for exactly one cycle. The pulse appears in the cycle after the sixth read is sampled.
- R3: The same five-read prefix followed by a read at 0x0C63 makes `recall_start` high for exactly one cycle, with the same timing as R2.
- R4: A write (`acc_wr` high) at any point in the pattern aborts it. The write never counts as a step, even when its address is 0x0E38.
- R5: A read at an address other than the one expected next aborts the pattern. This includes a sixth read that matches neither command address. If the aborting read is at 0x0E38, it counts as a new first step.
- R6: Cycles with neither strobe high leave the progress of the pattern unchanged.
- R7: A store holds `erase_active` for STORE_ERASE_CYC cycles, starting in the cycle of `store_start`. `program_active` then follows for STORE_PROG_CYC cycles. The two flags are never high together.
- R8: A recall holds `recall_active` for RECALL_CYC cycles, starting in the cycle of `recall_start`.
- R9: `busy` is high exactly while a phase flag is high. Accesses made while `busy` is high are ignored and do not advance the pattern. After `busy` falls, the pattern starts again from its first step.
- R10: An access with both strobes high is treated as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_rd | input | 1 | One-cycle read strobe |
| acc_wr | input | 1 | One-cycle write strobe |
| acc_addr | input | ADDR_W | Address of the access |
| store_start | output | 1 | One-cycle pulse when a store is accepted |
| recall_start | output | 1 | One-cycle pulse when a recall is accepted |
| busy | output | 1 | Device disabled during a store or recall |
| erase_active | output | 1 | Store erase phase in progress |
| program_active | output | 1 | Store program phase in progress |
| recall_active | output | 1 | Recall in progress |

## Verification
Every output is a register, so the effect of an access sampled at edge N is seen just after edge N. This holds for the start pulses, the rise of `busy` and the first phase flag. After that, each phase flag falls exactly its parameter count of cycles later. The bench applies each access at a falling edge and lets one rising edge pass. At the next falling edge it compares all six outputs against a cycle-accurate reference model kept in bench functions. Every cycle is checked in this way, including the cycles inside busy windows, so any error in pulse timing or phase length shows up in the cycle where it happens.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;

    localparam int NUM_PREFIX = 5;
    localparam int KEY_W      = 15;

    localparam logic [KEY_W-1:0] STORE_KEY  = 15'h0FC0;
    localparam logic [KEY_W-1:0] RECALL_KEY = 15'h0C63;

    typedef enum logic [1:0] {
        CMD_NONE   = 2'd0,
        CMD_STORE  = 2'd1,
        CMD_RECALL = 2'd2
    } cmd_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_ERASE  = 2'd1,
        PH_PROG   = 2'd2,
        PH_RECALL = 2'd3
    } nv_phase_e;

    // prefix address expected at step idx (0-based)
    function automatic logic [KEY_W-1:0] prefix_key(input int unsigned idx);
        logic [KEY_W-1:0] k;
        case (idx)
            0:       k = 15'h0E38;
            1:       k = 15'h31C7;
            2:       k = 15'h03E0;
            3:       k = 15'h3C1F;
            4:       k = 15'h303F;
            default: k = '0;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/rdseq_key_cmp.sv
module rdseq_key_cmp
    import rdseq_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic [ADDR_W-1:0]     addr,
    output logic [NUM_PREFIX-1:0] prefix_hit,
    output logic                  store_hit,
    output logic                  recall_hit
);

    localparam logic [ADDR_W-1:0] STORE_A  = ADDR_W'(STORE_KEY);
    localparam logic [ADDR_W-1:0] RECALL_A = ADDR_W'(RECALL_KEY);

    for (genvar gi = 0; gi < NUM_PREFIX; gi++) begin : g_prefix
        localparam logic [ADDR_W-1:0] KEY_A = ADDR_W'(prefix_key(gi));
        assign prefix_hit[gi] = (addr == KEY_A);
    end

    assign store_hit  = (addr == STORE_A);
    assign recall_hit = (addr == RECALL_A);

endmodule

// File: rtl/rdseq_matcher.sv
module rdseq_matcher
    import rdseq_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  acc_rd,
    input  logic                  acc_wr,
    input  logic [NUM_PREFIX-1:0] prefix_hit,
    input  logic                  store_hit,
    input  logic                  recall_hit,
    input  logic                  hold,
    output cmd_e                  cmd_req,
    output logic                  store_go,
    output logic                  recall_go
);

    localparam int STEP_W = $clog2(NUM_PREFIX + 1);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_PREFIX);

    typedef struct packed {
        logic [STEP_W-1:0] step;
        logic              store_go;
        logic              recall_go;
    } match_state_t;

    match_state_t st_q, st_d;

    always_comb begin
        st_d           = st_q;
        st_d.store_go  = 1'b0;
        st_d.recall_go = 1'b0;
        cmd_req        = CMD_NONE;
        if (!hold && (acc_rd || acc_wr)) begin
            if (acc_wr) begin
                // writes (and rd+wr together) always abort
                st_d.step = '0;
            end else if (st_q.step == LAST_STEP) begin
                if (store_hit) begin
                    cmd_req       = CMD_STORE;
                    st_d.store_go = 1'b1;
                    st_d.step     = '0;
                end else if (recall_hit) begin
                    cmd_req        = CMD_RECALL;
                    st_d.recall_go = 1'b1;
                    st_d.step      = '0;
                end else begin
                    st_d.step = prefix_hit[0] ? STEP_W'(1) : '0;
                end
            end else if (prefix_hit[st_q.step]) begin
                st_d.step = st_q.step + STEP_W'(1);
            end else begin
                st_d.step = prefix_hit[0] ? STEP_W'(1) : '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign store_go  = st_q.store_go;
    assign recall_go = st_q.recall_go;

    // R5: step counter never passes the last prefix step
    a_r5_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.step <= LAST_STEP);

    // R4: an accepted write leaves the pattern at step zero
    a_r4_write_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && !hold) |=> (st_q.step == '0));

    // R9: while held, the pattern cannot move
    a_r9_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(st_q.step));

    // R2: start pulses are exclusive and last one cycle
    a_r2_pulse_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({st_q.store_go, st_q.recall_go}));
    a_r2_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.store_go |=> !st_q.store_go);
    a_r3_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.recall_go |=> !st_q.recall_go);

endmodule

// File: rtl/rdseq_nv_timer.sv
module rdseq_nv_timer
    import rdseq_pkg::*;
#(
    parameter int STORE_ERASE_CYC = 20,
    parameter int STORE_PROG_CYC  = 40,
    parameter int RECALL_CYC      = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  cmd_e cmd_req,
    input  logic store_go,
    input  logic recall_go,
    output logic busy,
    output logic erase_active,
    output logic program_active,
    output logic recall_active
);

    localparam int MAX_A   = (STORE_ERASE_CYC > STORE_PROG_CYC) ? STORE_ERASE_CYC : STORE_PROG_CYC;
    localparam int MAX_CYC = (MAX_A > RECALL_CYC) ? MAX_A : RECALL_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    localparam logic [CNT_W-1:0] ERASE_LD  = CNT_W'(STORE_ERASE_CYC - 1);
    localparam logic [CNT_W-1:0] PROG_LD   = CNT_W'(STORE_PROG_CYC - 1);
    localparam logic [CNT_W-1:0] RECALL_LD = CNT_W'(RECALL_CYC - 1);

    typedef struct packed {
        nv_phase_e        phase;
        logic [CNT_W-1:0] cnt;
    } timer_state_t;

    timer_state_t tm_q, tm_d;

    always_comb begin
        tm_d = tm_q;
        case (tm_q.phase)
            PH_IDLE: begin
                if (cmd_req == CMD_STORE) begin
                    tm_d.phase = PH_ERASE;
                    tm_d.cnt   = ERASE_LD;
                end else if (cmd_req == CMD_RECALL) begin
                    tm_d.phase = PH_RECALL;
                    tm_d.cnt   = RECALL_LD;
                end
            end
            PH_ERASE: begin
                if (tm_q.cnt == '0) begin
                    tm_d.phase = PH_PROG;
                    tm_d.cnt   = PROG_LD;
                end else begin
                    tm_d.cnt = tm_q.cnt - CNT_W'(1);
                end
            end
            PH_PROG, PH_RECALL: begin
                if (tm_q.cnt == '0) begin
                    tm_d.phase = PH_IDLE;
                    tm_d.cnt   = '0;
                end else begin
                    tm_d.cnt = tm_q.cnt - CNT_W'(1);
                end
            end
            default: tm_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tm_q <= '0;
        end else begin
            tm_q <= tm_d;
        end
    end

    assign erase_active   = (tm_q.phase == PH_ERASE);
    assign program_active = (tm_q.phase == PH_PROG);
    assign recall_active  = (tm_q.phase == PH_RECALL);
    assign busy           = (tm_q.phase != PH_IDLE);

    // R7: phases are mutually exclusive
    a_r7_phase_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({erase_active, program_active, recall_active}));

    // R7: program only ever follows erase
    a_r7_prog_after_erase: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(program_active) |-> $past(erase_active));

    // R7: store pulse coincides with start of erase
    a_r7_erase_on_store: assert property (@(posedge clk) disable iff (!rst_n)
        store_go |-> (erase_active && !$past(busy)));

    // R8: recall pulse coincides with start of recall phase
    a_r8_recall_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        recall_go |-> (recall_active && !$past(busy)));

    // R9: busy only rises together with a start pulse
    a_r9_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (store_go || recall_go));

    // R9: no command is requested while busy
    a_r9_no_cmd_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cmd_req == CMD_NONE));

endmodule

// File: rtl/rdseq_cmd_top.sv
module rdseq_cmd_top
    import rdseq_pkg::*;
#(
    parameter int ADDR_W          = 15,
    parameter int STORE_ERASE_CYC = 20,
    parameter int STORE_PROG_CYC  = 40,
    parameter int RECALL_CYC      = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_rd,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              store_start,
    output logic              recall_start,
    output logic              busy,
    output logic              erase_active,
    output logic              program_active,
    output logic              recall_active
);

    logic [NUM_PREFIX-1:0] prefix_hit;
    logic                  store_hit;
    logic                  recall_hit;
    cmd_e                  cmd_req;

    rdseq_key_cmp #(.ADDR_W(ADDR_W)) u_cmp (
        .addr       (acc_addr),
        .prefix_hit (prefix_hit),
        .store_hit  (store_hit),
        .recall_hit (recall_hit)
    );

    rdseq_matcher #(.ADDR_W(ADDR_W)) u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_rd     (acc_rd),
        .acc_wr     (acc_wr),
        .prefix_hit (prefix_hit),
        .store_hit  (store_hit),
        .recall_hit (recall_hit),
        .hold       (busy),
        .cmd_req    (cmd_req),
        .store_go   (store_start),
        .recall_go  (recall_start)
    );

    rdseq_nv_timer #(
        .STORE_ERASE_CYC (STORE_ERASE_CYC),
        .STORE_PROG_CYC  (STORE_PROG_CYC),
        .RECALL_CYC      (RECALL_CYC)
    ) u_timer (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd_req        (cmd_req),
        .store_go       (store_start),
        .recall_go      (recall_start),
        .busy           (busy),
        .erase_active   (erase_active),
        .program_active (program_active),
        .recall_active  (recall_active)
    );

endmodule

// File: tb/rdseq_cmd_top_tb_top.sv
module rdseq_cmd_top_tb_top;

    localparam int ADDR_W = 15;
    localparam int ER_C   = 20;
    localparam int PG_C   = 40;
    localparam int RC_C   = 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_rd = 1'b0;
    logic acc_wr = 1'b0;
    logic [ADDR_W-1:0] acc_addr = '0;
    logic store_start, recall_start, busy, erase_active, program_active, recall_active;

    always #10 clk = ~clk;   // 50 MHz

    rdseq_cmd_top #(
        .ADDR_W(ADDR_W), .STORE_ERASE_CYC(ER_C),
        .STORE_PROG_CYC(PG_C), .RECALL_CYC(RC_C)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .acc_rd(acc_rd), .acc_wr(acc_wr),
        .acc_addr(acc_addr), .store_start(store_start), .recall_start(recall_start),
        .busy(busy), .erase_active(erase_active), .program_active(program_active),
        .recall_active(recall_active)
    );

    int errors = 0;
    int checks = 0;
    string cur_req = "R1";
    int n_store = 0;
    int n_recall = 0;
    bit finished = 0;

    // reference model state
    int m_step = 0;
    int m_mode = 0;      // 0 idle, 1 store, 2 recall
    int m_elapsed = 0;
    bit e_store, e_recall;

    function automatic logic [14:0] key(input int i);
        logic [14:0] tbl [0:4];
        tbl[0] = 15'h0E38; tbl[1] = 15'h31C7; tbl[2] = 15'h03E0;
        tbl[3] = 15'h3C1F; tbl[4] = 15'h303F;
        return tbl[i];
    endfunction

    localparam logic [14:0] K_STORE  = 15'h0FC0;
    localparam logic [14:0] K_RECALL = 15'h0C63;

    function automatic bit exp_busy();     return m_mode != 0; endfunction
    function automatic bit exp_erase();    return m_mode == 1 && m_elapsed < ER_C; endfunction
    function automatic bit exp_prog();     return m_mode == 1 && m_elapsed >= ER_C; endfunction
    function automatic bit exp_rcl();      return m_mode == 2; endfunction

    task automatic chk(input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic chk_int(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // advance the reference model across one rising edge
    task automatic model_step(input bit rd, input bit wr, input logic [14:0] a);
        e_store = 0; e_recall = 0;
        if (m_mode != 0) begin
            m_elapsed++;
            if (m_mode == 1 && m_elapsed >= ER_C + PG_C) m_mode = 0;
            if (m_mode == 2 && m_elapsed >= RC_C) m_mode = 0;
        end else if (rd || wr) begin
            if (wr) m_step = 0;
            else if (m_step == 5) begin
                if (a == K_STORE) begin m_mode = 1; m_elapsed = 0; e_store = 1; m_step = 0; end
                else if (a == K_RECALL) begin m_mode = 2; m_elapsed = 0; e_recall = 1; m_step = 0; end
                else m_step = (a == key(0)) ? 1 : 0;
            end else if (a == key(m_step)) m_step++;
            else m_step = (a == key(0)) ? 1 : 0;
        end
    endtask

    // called at a falling edge; drives one cycle, compares after the edge
    task automatic cyc(input bit rd, input bit wr, input logic [14:0] a);
        acc_rd = rd; acc_wr = wr; acc_addr = a;
        model_step(rd, wr, a);
        @(negedge clk);
        acc_rd = 0; acc_wr = 0;
        chk("store_start (R2)", store_start, e_store);
        chk("recall_start (R3)", recall_start, e_recall);
        chk("erase_active (R7)", erase_active, exp_erase());
        chk("program_active (R7)", program_active, exp_prog());
        chk("recall_active (R8)", recall_active, exp_rcl());
        chk("busy (R9)", busy, exp_busy());
        if (store_start === 1'b1) n_store++;
        if (recall_start === 1'b1) n_recall++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, '0);
    endtask

    task automatic prefix(input int upto);
        for (int i = 0; i < upto; i++) cyc(1, 0, key(i));
    endtask

    task automatic drain();
        while (m_mode != 0) cyc(0, 0, '0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        int s0, r0;
        void'($urandom(32'd20240611));
        // R1 reset state
        cur_req = "R1";
        repeat (3) @(negedge clk);
        chk("busy in reset (R1)", busy, 0);
        chk("store_start in reset (R1)", store_start, 0);
        chk("recall_start in reset (R1)", recall_start, 0);
        chk("erase in reset (R1)", erase_active | program_active | recall_active, 0);
        rst_n = 1;
        idle(2);

        // R2 + R7 store sequence
        cur_req = "R2";
        s0 = n_store;
        prefix(5); cyc(1, 0, K_STORE);
        chk("erase after store (R7)", erase_active, 1);
        drain(); idle(1);
        chk_int("R2", "store pulses", n_store - s0, 1);

        // R3 + R8 recall
        cur_req = "R3";
        r0 = n_recall;
        prefix(5); cyc(1, 0, K_RECALL);
        chk("recall active (R8)", recall_active, 1);
        drain(); idle(1);
        chk_int("R3", "recall pulses", n_recall - r0, 1);

        // R4 write aborts, incl. write at first key
        cur_req = "R4";
        s0 = n_store;
        prefix(3); cyc(0, 1, key(3)); cyc(1, 0, key(4)); cyc(1, 0, K_STORE);
        prefix(2); cyc(0, 1, key(0)); prefix(5); cyc(1, 0, K_STORE);
        drain();
        chk_int("R4", "store pulses after write aborts", n_store - s0, 1);

        // R5 wrong read restarts; 0x0E38 counts as step one; bad sixth read
        cur_req = "R5";
        s0 = n_store;
        prefix(3); cyc(1, 0, key(0));
        for (int i = 1; i < 5; i++) cyc(1, 0, key(i));
        cyc(1, 0, K_STORE);
        drain();
        chk_int("R5", "restart via first key", n_store - s0, 1);
        s0 = n_store; r0 = n_recall;
        prefix(5); cyc(1, 0, 15'h1234); cyc(1, 0, K_STORE); cyc(1, 0, K_RECALL);
        chk_int("R5", "bad sixth read stores", n_store - s0, 0);
        chk_int("R5", "bad sixth read recalls", n_recall - r0, 0);

        // R6 idle gaps
        cur_req = "R6";
        r0 = n_recall;
        for (int i = 0; i < 5; i++) begin cyc(1, 0, key(i)); idle(i + 1); end
        idle(3); cyc(1, 0, K_RECALL);
        drain();
        chk_int("R6", "recall with gaps", n_recall - r0, 1);

        // R9 accesses during busy ignored
        cur_req = "R9";
        prefix(5); cyc(1, 0, K_STORE);
        s0 = n_store; r0 = n_recall;
        prefix(5); cyc(1, 0, K_STORE); cyc(1, 0, K_RECALL);
        drain();
        cyc(1, 0, K_STORE);
        idle(1);
        chk_int("R9", "starts from busy traffic", n_store - s0 + n_recall - r0, 0);

        // R10 rd and wr together abort
        cur_req = "R10";
        s0 = n_store;
        prefix(3); cyc(1, 1, key(3)); cyc(1, 0, key(4)); cyc(1, 0, K_STORE);
        chk_int("R10", "rd+wr abort", n_store - s0, 0);

        // constrained random mix
        cur_req = "R5";
        for (int i = 0; i < 6000; i++) begin
            int p = $urandom_range(99);
            bit rd = 0, wr = 0;
            logic [14:0] a;
            if (p < 60) rd = 1; else if (p < 66) wr = 1; else if (p < 68) begin rd = 1; wr = 1; end
            p = $urandom_range(99);
            if (p < 70) a = key(m_step < 5 ? m_step : 0);
            else if (p < 78) a = K_STORE;
            else if (p < 86) a = K_RECALL;
            else if (p < 92) a = key($urandom_range(4));
            else a = 15'($urandom);
            cyc(rd, wr, a);
        end
        drain();

        finished = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule